// File: doc/BRIEF.md
# Paired Compare-Point PWM Generator

This unit produces five pulse-width modulated outputs grouped into three channel pairs. Each pair owns a 16-bit up-counting timer whose period is set by a length value. A high-side output rises and falls at two compare points. In the first two pairs, a low-side output rises when the timer reaches the period length. It falls at its own compare point, or as soon as its high-side partner falls. The third pair has a high side only. All timers advance on a shared tick, which is the unit clock divided by a programmable power of two.

Software programs the unit through a write-only register port. Compare and length writes land in shadow copies. The running values take them over only when a period wraps, or at once while the unit is disabled, so a period never runs with a mix of old and new settings. Each pair raises a sticky interrupt flag when its period wraps, and a write to the clear address drops all flags. After reset the unit sits in a safe state with every output held low, and software must select standard mode before any pulse appears.

Top module: `pwm_pair_unit`

## Requirements
- R1: Control bits [3:1] hold a divide code k. While enabled, a free-running 8-bit prescale count starts from zero, and a timer tick occurs on each clock where the count modulo 2^(k+1) equals 2^(k+1)-1. This gives one tick every 2, 4, ... 256 clocks.
- R2: On a tick, a pair's timer holding its active length value returns to 0; otherwise it increments by one. Between ticks the timer holds.
- R3: On a tick where the timer equals the rise compare, the high-side output goes to 1. Where it equals the fall compare, it goes to 0. When both match, the fall wins.
- R4: In pairs 0 and 1, the low-side output goes to 1 on the tick where the timer equals the active length.
- R5: The low-side output goes to 0 on a tick where the timer equals its low compare, or where its high side falls. A fall wins over a rise in the same tick.
- R6: Compare and length writes go to shadow registers. The active values take them over at the wrap tick, and on every clock while the enable bit is 0.
- R7: On a pair's wrap tick its interrupt flag goes to 1 and stays there. A write of any data to address 12 clears all flags, except that a flag set in the same cycle stays 1.
- R8: Control bit 0 is the enable. While it is 0, the prescale count and all timers are held at zero and all high-side and low-side states are cleared.
- R9: The control register resets to 0x0012, which is disabled, divide code 1 and safe mode. While control bit 4 (safe) is 1, all five outputs are low. Writing it to 0 selects standard mode.
- R10: Register addresses are as follows: control at 0; pair 0 rise/fall/low/length at 1/2/3/4; pair 1 at 5/6/7/8; interrupt clear at 12. Writes to 13 to 15 have no effect.
- R11: Pair 2 has a high side only, with rise, fall and length at addresses 9, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_hi | output | 3 | High-side outputs, one per pair |
| pwm_lo | output | 2 | Low-side outputs of pairs 0 and 1 |
| irq | output | 3 | Sticky end-of-period flags, one per pair |

## Verification
Some cases are hard to reach from the ports because they need several events in the same prescaled tick. Examples are a high-side fall that ends a low-side pulse, or a wrap that coincides with an interrupt-clear write. The stimulus reaches these with zero or tiny period lengths, so every tick is a wrap. It also uses clear writes on every clock and compare values that equal each other or the length. Writes that land mid-period and random register writes during running, under varied divide codes, exercise the shadow hand-over against a bench model that works out every output per clock.

// File: rtl/pwm_pair_pkg.sv
`timescale 1ns/1ps
package pwm_pair_pkg;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_DIV_LSB  = 1;
  localparam int DIV_W         = 3;
  localparam int CTRL_SAFE_BIT = 4;
  localparam int CTRL_W        = 5;
  localparam logic [15:0] CTRL_RESET = 16'h0012;
  localparam int PS_CNT_W      = 1 << DIV_W;

  localparam int F_RISE = 0;
  localparam int F_FALL = 1;
  localparam int F_LOW  = 2;
  localparam int F_LEN  = 3;

  // low bits of the prescale count that must all be set for a tick
  function automatic logic [PS_CNT_W-1:0] div_mask(input logic [DIV_W-1:0] code);
    return {PS_CNT_W{1'b1}} >> (PS_CNT_W - 1 - int'(code));
  endfunction

  // output level update: a fall event beats a rise event
  function automatic logic next_level(input logic cur, input logic rise, input logic fall);
    if (fall) return 1'b0;
    if (rise) return 1'b1;
    return cur;
  endfunction

  // register address of a field; pairs with a low side use four slots
  function automatic int reg_addr(input int n_lo, input int pair, input int field);
    if (pair < n_lo) return 1 + 4 * pair + field;
    return 1 + 4 * n_lo + 3 * (pair - n_lo) + ((field == F_LEN) ? 2 : field);
  endfunction

  function automatic int clr_addr(input int n_lo, input int n_pairs);
    return 1 + 4 * n_lo + 3 * (n_pairs - n_lo);
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
`timescale 1ns/1ps
module pwm_prescaler
  import pwm_pair_pkg::*;
#(
  parameter int CODE_W = DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CW = 1 << CODE_W;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;

  assign mask = CW'(div_mask(DIV_W'(code)));
  assign tick = en && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= cnt_q + CW'(1);
    else         cnt_q <= '0;
  end

  // R1
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
  // R8
  tick_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_pair_core.sv
`timescale 1ns/1ps
module pwm_pair_core
  import pwm_pair_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [TW-1:0] rise_sh,
  input  logic [TW-1:0] fall_sh,
  input  logic [TW-1:0] len_sh,
  output logic [TW-1:0] timer,
  output logic          hi,
  output logic          hi_fall,
  output logic          wrap
);
  logic [TW-1:0] rise_a, fall_a, len_a, timer_q;
  logic          hi_q;
  logic          rise_hit, fall_hit;

  assign rise_hit = tick && (timer_q == rise_a);
  assign fall_hit = tick && (timer_q == fall_a);
  assign wrap     = tick && (timer_q == len_a);
  assign hi_fall  = hi_q && fall_hit;
  assign timer    = timer_q;
  assign hi       = hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_a  <= '0;
      fall_a  <= '0;
      len_a   <= '0;
      timer_q <= '0;
      hi_q    <= 1'b0;
    end else if (!en) begin
      rise_a  <= rise_sh;
      fall_a  <= fall_sh;
      len_a   <= len_sh;
      timer_q <= '0;
      hi_q    <= 1'b0;
    end else begin
      hi_q <= next_level(hi_q, rise_hit, fall_hit);
      if (wrap) begin
        rise_a  <= rise_sh;
        fall_a  <= fall_sh;
        len_a   <= len_sh;
        timer_q <= '0;
      end else if (tick) begin
        timer_q <= timer_q + TW'(1);
      end
    end
  end

  // R2
  timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_q <= len_a);
  // R2
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !tick) |=> $stable(timer_q));
  // R3
  hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> $past(tick && (timer_q == rise_a)));
  // R8
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (timer_q == '0 && !hi_q));
endmodule

// File: rtl/pwm_low_side.sv
`timescale 1ns/1ps
module pwm_low_side
  import pwm_pair_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          wrap,
  input  logic          hi_fall,
  input  logic [TW-1:0] timer,
  input  logic [TW-1:0] low_sh,
  output logic          lo
);
  logic [TW-1:0] low_a;
  logic          lo_q;
  logic          clr_evt;

  assign clr_evt = hi_fall || (tick && (timer == low_a));
  assign lo      = lo_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_a <= '0;
      lo_q  <= 1'b0;
    end else if (!en) begin
      low_a <= low_sh;
      lo_q  <= 1'b0;
    end else begin
      if (wrap) low_a <= low_sh;
      lo_q <= next_level(lo_q, wrap, clr_evt);
    end
  end

  // R4
  lo_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_q) |-> $past(wrap));
  // R5
  lo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_fall |=> !lo_q);
endmodule

// File: rtl/pwm_pair_unit.sv
`timescale 1ns/1ps
module pwm_pair_unit
  import pwm_pair_pkg::*;
#(
  parameter int NUM_PAIRS = 3,
  parameter int NUM_LO    = 2,
  parameter int TW        = 16,
  parameter int AW        = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [TW-1:0]        wr_data,
  output logic [NUM_PAIRS-1:0] pwm_hi,
  output logic [NUM_LO-1:0]    pwm_lo,
  output logic [NUM_PAIRS-1:0] irq
);
  localparam int CLR_ADDR = clr_addr(NUM_LO, NUM_PAIRS);

  logic [CTRL_W-1:0]    ctrl_q;
  logic                 ctrl_en, ctrl_safe;
  logic [DIV_W-1:0]     div_code;
  logic [TW-1:0]        sh_rise [NUM_PAIRS];
  logic [TW-1:0]        sh_fall [NUM_PAIRS];
  logic [TW-1:0]        sh_len  [NUM_PAIRS];
  logic [TW-1:0]        sh_low  [NUM_LO];
  logic                 tick;
  logic [TW-1:0]        timer_w [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] hi_w, hi_fall_w, wrap_w, irq_q;
  logic [NUM_LO-1:0]    lo_w;
  logic                 clr_wr;

  assign ctrl_en   = ctrl_q[CTRL_EN_BIT];
  assign ctrl_safe = ctrl_q[CTRL_SAFE_BIT];
  assign div_code  = ctrl_q[CTRL_DIV_LSB +: DIV_W];
  assign clr_wr    = wr_en && (wr_addr == AW'(CLR_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RESET[CTRL_W-1:0];
      for (int p = 0; p < NUM_PAIRS; p++) begin
        sh_rise[p] <= '0;
        sh_fall[p] <= '0;
        sh_len[p]  <= '0;
      end
      for (int p = 0; p < NUM_LO; p++) sh_low[p] <= '0;
    end else if (wr_en) begin
      if (wr_addr == '0) ctrl_q <= wr_data[CTRL_W-1:0];
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (wr_addr == AW'(reg_addr(NUM_LO, p, F_RISE))) sh_rise[p] <= wr_data;
        if (wr_addr == AW'(reg_addr(NUM_LO, p, F_FALL))) sh_fall[p] <= wr_data;
        if (wr_addr == AW'(reg_addr(NUM_LO, p, F_LEN)))  sh_len[p]  <= wr_data;
      end
      for (int p = 0; p < NUM_LO; p++)
        if (wr_addr == AW'(reg_addr(NUM_LO, p, F_LOW))) sh_low[p] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= wrap_w | (clr_wr ? '0 : irq_q);
  end

  pwm_prescaler #(.CODE_W(DIV_W)) u_presc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (ctrl_en),
    .code (div_code),
    .tick (tick)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    pwm_pair_core #(.TW(TW)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (ctrl_en),
      .tick   (tick),
      .rise_sh(sh_rise[p]),
      .fall_sh(sh_fall[p]),
      .len_sh (sh_len[p]),
      .timer  (timer_w[p]),
      .hi     (hi_w[p]),
      .hi_fall(hi_fall_w[p]),
      .wrap   (wrap_w[p])
    );

    if (p < NUM_LO) begin : g_lo
      pwm_low_side #(.TW(TW)) u_low (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctrl_en),
        .tick   (tick),
        .wrap   (wrap_w[p]),
        .hi_fall(hi_fall_w[p]),
        .timer  (timer_w[p]),
        .low_sh (sh_low[p]),
        .lo     (lo_w[p])
      );
    end

    // R7
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_w[p] |=> irq_q[p]);
    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q[p] && !clr_wr) |=> irq_q[p]);
    // R2
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_w[p] |=> (timer_w[p] == '0));
  end

  assign pwm_hi = ctrl_safe ? '0 : hi_w;
  assign pwm_lo = ctrl_safe ? '0 : lo_w;
  assign irq    = irq_q;

  // R9
  safe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_addr == '0 && wr_data[CTRL_SAFE_BIT]) |-> (pwm_hi == '0 && pwm_lo == '0));
endmodule

// File: tb/pwm_pair_unit_test.sv
`timescale 1ns/1ps
module pwm_pair_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  pwm_hi;
  logic [1:0]  pwm_lo;
  logic [2:0]  irq;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    running = 1'b0;
  bit    done = 1'b0;
  string tag = "R9";

  pwm_pair_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // ---------------- reference model, built from the requirements ----------------
  logic [4:0]  m_ctrl;
  logic [15:0] m_sh  [16];
  logic [15:0] m_act [3][4];
  int          m_t   [3];
  bit   [2:0]  m_h, m_irq;
  bit   [1:0]  m_l;
  int          m_pc;

  // address of field f (0 rise, 1 fall, 2 low, 3 length) of pair p, per R10/R11
  function automatic int fld_addr(int p, int f);
    if (p < 2) return 1 + 4 * p + f;
    case (f)
      0: return 9;
      1: return 10;
      3: return 11;
      default: return -1;
    endcase
  endfunction

  function automatic bit is_tick(int pc, logic [4:0] c);
    int d = 2 << int'(c[3:1]);
    return c[0] && ((pc % d) == d - 1);
  endfunction

  function automatic logic [7:0] expect_out();
    bit std = !m_ctrl[4];
    return {m_h & {3{std}}, m_l & {2{std}}, m_irq};
  endfunction

  task automatic load_act(int p);
    for (int f = 0; f < 4; f++)
      if (fld_addr(p, f) >= 0) m_act[p][f] = m_sh[fld_addr(p, f)];
  endtask

  task automatic model_step();
    bit tk  = is_tick(m_pc, m_ctrl);
    bit clr = wr_en && (wr_addr == 4'd12);
    bit [2:0] wr = '0;
    for (int p = 0; p < 3; p++) begin
      if (!m_ctrl[0]) begin
        m_t[p] = 0; m_h[p] = 0;
        if (p < 2) m_l[p] = 0;
        load_act(p);
      end else if (tk) begin
        int v = m_t[p];
        bit nh = m_h[p];
        bit fall;
        if (v == int'(m_act[p][0])) nh = 1;
        if (v == int'(m_act[p][1])) nh = 0;
        fall = m_h[p] && (v == int'(m_act[p][1]));
        if (p < 2) begin
          bit nl = m_l[p];
          if (v == int'(m_act[p][3])) nl = 1;
          if (v == int'(m_act[p][2]) || fall) nl = 0;
          m_l[p] = nl;
        end
        m_h[p] = nh;
        if (v == int'(m_act[p][3])) begin
          m_t[p] = 0; wr[p] = 1; load_act(p);
        end else m_t[p] = v + 1;
      end
    end
    m_pc = m_ctrl[0] ? (m_pc + 1) % 256 : 0;
    for (int p = 0; p < 3; p++)
      if (wr[p]) m_irq[p] = 1;
      else if (clr) m_irq[p] = 0;
    if (wr_en) begin
      if (wr_addr == 4'd0) m_ctrl = wr_data[4:0];
      else if (wr_addr <= 4'd11) m_sh[wr_addr] = wr_data;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 5'h12; m_pc = 0; m_h = '0; m_l = '0; m_irq = '0;
      for (int i = 0; i < 16; i++) m_sh[i] = '0;
      for (int p = 0; p < 3; p++) begin
        m_t[p] = 0;
        for (int f = 0; f < 4; f++) m_act[p][f] = '0;
      end
    end else model_step();
  end

  // ---------------- checking ----------------
  task automatic check_now();
    logic [7:0] got = {pwm_hi, pwm_lo, irq};
    logic [7:0] exp = expect_out();
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: {hi,lo,irq} got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && running) check_now();

  // ---------------- stimulus helpers ----------------
  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
  endtask

  task automatic run(int n, bit rnd);
    repeat (n) begin
      @(negedge clk);
      if (rnd && ($urandom % 20 == 0)) begin
        wr_en = 1'b1;
        wr_addr = 4'($urandom % 16);
        if (wr_addr == 4'd0) wr_data = 16'(($urandom % 8 == 0) ? ($urandom & 31) : (($urandom & 22) | 1));
        else wr_data = 16'($urandom % 24);
      end else wr_en = 1'b0;
    end
  endtask

  task automatic set_pair(int p, int r, int f, int lw, int ln);
    wr(fld_addr(p, 0), r);
    wr(fld_addr(p, 1), f);
    if (p < 2) wr(fld_addr(p, 2), lw);
    wr(fld_addr(p, 3), ln);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R9: reset state, outputs quiet
    repeat (3) @(negedge clk);
    tag = "R9";
    check_now();
    rst_n = 1'b1;
    running = 1'b1;
    run(20, 0);

    // R10 R11: program every pair, check while still in safe reset mode (R9)
    tag = "R10";
    set_pair(0, 2, 6, 4, 9);
    set_pair(1, 0, 3, 8, 5);
    set_pair(2, 1, 7, 0, 12);
    wr(0, 16'h0011);
    tag = "R9";
    run(80, 0);
    tag = "R11";
    wr(0, 16'h0001);
    run(150, 0);
    // writes to unused addresses change nothing (R10)
    tag = "R10";
    wr(13, 3); wr(14, 0); wr(15, 7);
    run(100, 0);

    // R1: every divide code
    for (int k = 0; k < 8; k++) begin
      tag = "R1";
      set_pair(0, 1, 3, 2, 3);
      wr(0, (k << 1) | 1);
      run(4 * (2 << k) + 60, 0);
    end

    // R2 R4: zero and one-count periods
    tag = "R2";
    wr(0, 0);
    set_pair(0, 0, 1, 5, 1);
    set_pair(1, 0, 5, 5, 0);
    set_pair(2, 0, 0, 0, 1);
    wr(0, 1);
    run(60, 0);
    tag = "R4";
    set_pair(0, 7, 7, 9, 4);
    run(80, 0);

    // R3: rise and fall compares equal, fall wins
    tag = "R3";
    set_pair(0, 2, 2, 9, 6);
    set_pair(2, 3, 3, 0, 5);
    run(80, 0);

    // R5: high-side fall ends the low pulse; low compare equal to length
    tag = "R5";
    set_pair(0, 1, 3, 7, 9);
    set_pair(1, 0, 2, 5, 5);
    run(120, 0);

    // R6: mid-period shadow writes with a long period
    tag = "R6";
    set_pair(0, 5, 30, 35, 40);
    run(110, 0);
    wr(4, 10); wr(1, 2);
    run(100, 0);

    // R7: clear writes on every clock against a pair wrapping each tick
    tag = "R7";
    set_pair(1, 0, 1, 1, 0);
    run(20, 0);
    for (int i = 0; i < 40; i++) wr(12, i);
    run(30, 0);
    wr(12, 0);
    run(30, 0);

    // R8: disable mid-run, rewrite while disabled, re-enable
    tag = "R8";
    wr(0, 16'h0002);
    run(20, 0);
    set_pair(0, 1, 2, 3, 4);
    run(10, 0);
    wr(0, 16'h0001);
    run(60, 0);

    // R10: random programming with random writes during running
    for (int r = 0; r < 25; r++) begin
      tag = "R10";
      for (int p = 0; p < 3; p++)
        set_pair(p, $urandom % 22, $urandom % 22, $urandom % 22, $urandom % 20);
      wr(0, (($urandom % 5 == 0) ? 16 : 0) | (($urandom % 4) << 1) | (($urandom % 10 == 0) ? 0 : 1));
      run(400, 1);
    end

    running = 1'b0;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no end of stimulus, expected end before %0t", $time);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule